// File: doc/BRIEF.md
# Row-Column Iterated Parity Codec

This block protects a rectangular array of data bits with a two-dimensional parity code. Every row of the array has an even-parity check bit, every column has an even-parity check bit, and a single corner bit carries parity over the check bits. The corner bit equals the parity of the row checks, which is also the parity of the column checks and of the whole data array. As a result, a complete valid block (data, row checks, column checks and corner) always holds an even number of ones.

The encoder path takes a data array and returns its row checks, column checks and corner bit one clock later. The decoder path takes a whole stored block in parallel, including all check bits. It recomputes every parity and finds the failing rows, the failing columns and the overall parity. From these it either passes the block through, repairs one bit, or flags the block as uncorrectable. Any single flipped bit is repaired: a data bit, a row check, a column check or the corner bit. Any two flipped bits are detected. Both paths are registered and have a latency of one cycle.

Data bit (r, c) sits at index r*COLS + c of the flat data vector. Row r's check is bit r of the row vector, and column c's check is bit c of the column vector.

Top module: `rc_parity_codec`

## Requirements
- R1: One cycle after `enc_valid_i`, bit r of `enc_row_o` makes row r of the data (bits r*COLS to r*COLS+COLS-1) even in parity.
- R2: One cycle after `enc_valid_i`, bit c of `enc_col_o` makes column c of the data (bits c, COLS+c, 2*COLS+c, ...) even in parity.
- R3: `enc_corner_o` is the XOR of all row check bits, and equals the XOR of all column check bits.
- R4: Each output valid follows its input valid by exactly one clock. A low `rst_n` at a clock edge clears both valids, both flags and all registered outputs to zero, even if input valids are high.
- R5: A block in which every row, every column and the overall parity check out is output unchanged, with both flags low.
- R6: A block with exactly one data bit flipped is output with that bit restored, all check bits unchanged, `dec_fixed_o` high and `dec_uncorr_o` low.
- R7: A block with exactly one row check bit or one column check bit flipped is output with that check bit restored, the data unchanged, and `dec_fixed_o` high.
- R8: A block with only the corner bit flipped is output with the corner restored and `dec_fixed_o` high.
- R9: A block with any two bits flipped raises `dec_uncorr_o`, keeps `dec_fixed_o` low, and outputs every data and check bit exactly as received.
- R10: `dec_fixed_o` and `dec_uncorr_o` are never high together, and both are low whenever `dec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_data_i | input | ROWS*COLS | Data array to encode, bit r*COLS+c |
| enc_valid_o | output | 1 | Encoder result valid |
| enc_row_o | output | ROWS | Row check bits |
| enc_col_o | output | COLS | Column check bits |
| enc_corner_o | output | 1 | Check-on-checks bit |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_data_i | input | ROWS*COLS | Received data array |
| dec_row_i | input | ROWS | Received row check bits |
| dec_col_i | input | COLS | Received column check bits |
| dec_corner_i | input | 1 | Received corner bit |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | ROWS*COLS | Corrected data array |
| dec_row_o | output | ROWS | Corrected row check bits |
| dec_col_o | output | COLS | Corrected column check bits |
| dec_corner_o | output | 1 | Corrected corner bit |
| dec_fixed_o | output | 1 | One bit was repaired |
| dec_uncorr_o | output | 1 | Error detected but not repairable |

## Verification
The encoder is checked with all-zero, all-one, checkerboard and pseudo-random arrays, so that even and odd row and column weights both occur. The decoder receives clean codewords, each single-bit error position in turn, and paired errors. The single-bit cases cover every data position, every row check, every column check and the corner; they separate the intersection repair from the repairs of a lone row check, a lone column check and the corner. The paired errors cover two bits in one row, two in one column, two at unrelated positions, a data bit together with its own row check, a row check with a column check, and a check bit with the corner. Each of these pairs either mimics a single error in some coordinate or cancels a syndrome, so together they confirm that the overall parity keeps every double error from being miscorrected.

// File: rtl/rc_pkg.sv
// Shared types for the row-column parity codec.
package rc_pkg;

    // Decoder verdict derived from the row, column and overall syndromes.
    typedef enum logic [2:0] {
        VERDICT_CLEAN  = 3'd0,
        VERDICT_DATA   = 3'd1,
        VERDICT_ROWCHK = 3'd2,
        VERDICT_COLCHK = 3'd3,
        VERDICT_CORNER = 3'd4,
        VERDICT_UNCORR = 3'd5
    } verdict_e;

endpackage

// File: rtl/rc_parity_plane.sv
// rc_parity_plane: combinational parity of every row and every column of a
// flat ROWS x COLS data array. Assumes bit (r, c) sits at index r*COLS + c.
module rc_parity_plane #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic [ROWS*COLS-1:0] data_i,
    output logic [ROWS-1:0]      row_par_o,
    output logic [COLS-1:0]      col_par_o
);
    localparam int NBITS = ROWS * COLS;

    // One XOR reduction per row over its contiguous slice.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par_o[r] = ^data_i[r*COLS +: COLS];
    end

    // One XOR reduction per column over a strided set of bits.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] column_bits;
        for (genvar r = 0; r < ROWS; r++) begin : g_pick
            assign column_bits[r] = data_i[r*COLS + c];
        end
        assign col_par_o[c] = ^column_bits;
    end

    // Keep the derived size visible for elaboration-time sanity.
    initial begin
        if (NBITS < 4) $display("rc_parity_plane: array smaller than 2x2");
    end
endmodule

// File: rtl/rc_syndrome_classify.sv
// rc_syndrome_classify: turns row and column syndromes plus the overall
// block parity into a verdict. Assumes a valid block has even overall parity,
// so odd parity means an odd number of flips and even parity with a nonzero
// syndrome means an even, uncorrectable number.
module rc_syndrome_classify
    import rc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic [ROWS-1:0] row_syn_i,
    input  logic [COLS-1:0] col_syn_i,
    input  logic            odd_i,
    output verdict_e        verdict_o
);
    logic row_any, col_any, row_one, col_one;

    // Reduce each syndrome vector to "none", "exactly one" or "several".
    always_comb begin
        row_any = |row_syn_i;
        col_any = |col_syn_i;
        row_one = $onehot(row_syn_i);
        col_one = $onehot(col_syn_i);
    end

    // Pick the verdict: odd parity with a single coordinate is repairable.
    always_comb begin
        if (!odd_i) begin
            verdict_o = (row_any || col_any) ? VERDICT_UNCORR : VERDICT_CLEAN;
        end else if (row_one && col_one) begin
            verdict_o = VERDICT_DATA;
        end else if (row_one && !col_any) begin
            verdict_o = VERDICT_ROWCHK;
        end else if (!row_any && col_one) begin
            verdict_o = VERDICT_COLCHK;
        end else if (!row_any && !col_any) begin
            verdict_o = VERDICT_CORNER;
        end else begin
            verdict_o = VERDICT_UNCORR;
        end
    end
endmodule

// File: rtl/rc_correct_apply.sv
// rc_correct_apply: applies the verdict to the received block. Inverts the
// data bit at the failing row/column intersection, or the lone failing check
// bit, or the corner; passes everything through otherwise.
module rc_correct_apply
    import rc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  verdict_e              verdict_i,
    input  logic [ROWS-1:0]       row_syn_i,
    input  logic [COLS-1:0]       col_syn_i,
    input  logic [ROWS*COLS-1:0]  data_i,
    input  logic [ROWS-1:0]       row_i,
    input  logic [COLS-1:0]       col_i,
    input  logic                  corner_i,
    output logic [ROWS*COLS-1:0]  data_o,
    output logic [ROWS-1:0]       row_o,
    output logic [COLS-1:0]       col_o,
    output logic                  corner_o,
    output logic                  fixed_o,
    output logic                  uncorr_o
);
    localparam int NBITS = ROWS * COLS;

    logic             hit_data;
    logic [NBITS-1:0] flip_mask;

    // Decode the verdict into the data-repair enable.
    assign hit_data = (verdict_i == VERDICT_DATA);

    // Outer product of the syndromes selects the single data bit to invert.
    for (genvar r = 0; r < ROWS; r++) begin : g_mr
        for (genvar c = 0; c < COLS; c++) begin : g_mc
            assign flip_mask[r*COLS + c] = hit_data & row_syn_i[r] & col_syn_i[c];
        end
    end

    // Build the repaired block and the two flags.
    always_comb begin
        data_o   = data_i ^ flip_mask;
        row_o    = (verdict_i == VERDICT_ROWCHK) ? (row_i ^ row_syn_i) : row_i;
        col_o    = (verdict_i == VERDICT_COLCHK) ? (col_i ^ col_syn_i) : col_i;
        corner_o = (verdict_i == VERDICT_CORNER) ? ~corner_i : corner_i;
        fixed_o  = (verdict_i != VERDICT_CLEAN) && (verdict_i != VERDICT_UNCORR);
        uncorr_o = (verdict_i == VERDICT_UNCORR);
    end
endmodule

// File: rtl/rc_parity_codec.sv
// rc_parity_codec: two-dimensional even-parity codec. The encoder produces
// row checks, column checks and a check-on-checks corner one cycle after a
// valid input. The decoder takes a whole block in parallel and, one cycle
// later, returns it repaired (single error) or flagged (double error).
// Assumes the corner bit is the parity of the row checks, so that a valid
// block has even overall weight.
module rc_parity_codec
    import rc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enc_valid_i,
    input  logic [ROWS*COLS-1:0]  enc_data_i,
    output logic                  enc_valid_o,
    output logic [ROWS-1:0]       enc_row_o,
    output logic [COLS-1:0]       enc_col_o,
    output logic                  enc_corner_o,
    input  logic                  dec_valid_i,
    input  logic [ROWS*COLS-1:0]  dec_data_i,
    input  logic [ROWS-1:0]       dec_row_i,
    input  logic [COLS-1:0]       dec_col_i,
    input  logic                  dec_corner_i,
    output logic                  dec_valid_o,
    output logic [ROWS*COLS-1:0]  dec_data_o,
    output logic [ROWS-1:0]       dec_row_o,
    output logic [COLS-1:0]       dec_col_o,
    output logic                  dec_corner_o,
    output logic                  dec_fixed_o,
    output logic                  dec_uncorr_o
);
    localparam int NBITS = ROWS * COLS;

    // ---------------- encoder path ----------------
    logic [ROWS-1:0] enc_row_c;
    logic [COLS-1:0] enc_col_c;

    rc_parity_plane #(.ROWS(ROWS), .COLS(COLS)) u_enc_plane (
        .data_i    (enc_data_i),
        .row_par_o (enc_row_c),
        .col_par_o (enc_col_c)
    );

    // Register the check bits of each accepted data array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid_o  <= 1'b0;
            enc_row_o    <= '0;
            enc_col_o    <= '0;
            enc_corner_o <= 1'b0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) begin
                enc_row_o    <= enc_row_c;
                enc_col_o    <= enc_col_c;
                enc_corner_o <= ^enc_row_c;
            end
        end
    end

    // ---------------- decoder path ----------------
    logic [ROWS-1:0]  dec_row_c, row_syn;
    logic [COLS-1:0]  dec_col_c, col_syn;
    logic             block_odd;
    verdict_e         verdict;
    logic [NBITS-1:0] fix_data;
    logic [ROWS-1:0]  fix_row;
    logic [COLS-1:0]  fix_col;
    logic             fix_corner, fix_flag, unc_flag;

    rc_parity_plane #(.ROWS(ROWS), .COLS(COLS)) u_dec_plane (
        .data_i    (dec_data_i),
        .row_par_o (dec_row_c),
        .col_par_o (dec_col_c)
    );

    // Syndromes: recomputed parity against the stored checks, plus the
    // parity of the whole block (data parity equals XOR of row parities).
    always_comb begin
        row_syn   = dec_row_c ^ dec_row_i;
        col_syn   = dec_col_c ^ dec_col_i;
        block_odd = (^dec_row_c) ^ (^dec_row_i) ^ (^dec_col_i) ^ dec_corner_i;
    end

    rc_syndrome_classify #(.ROWS(ROWS), .COLS(COLS)) u_classify (
        .row_syn_i (row_syn),
        .col_syn_i (col_syn),
        .odd_i     (block_odd),
        .verdict_o (verdict)
    );

    rc_correct_apply #(.ROWS(ROWS), .COLS(COLS)) u_apply (
        .verdict_i (verdict),
        .row_syn_i (row_syn),
        .col_syn_i (col_syn),
        .data_i    (dec_data_i),
        .row_i     (dec_row_i),
        .col_i     (dec_col_i),
        .corner_i  (dec_corner_i),
        .data_o    (fix_data),
        .row_o     (fix_row),
        .col_o     (fix_col),
        .corner_o  (fix_corner),
        .fixed_o   (fix_flag),
        .uncorr_o  (unc_flag)
    );

    // Register the repaired block; flags only live alongside a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o  <= 1'b0;
            dec_data_o   <= '0;
            dec_row_o    <= '0;
            dec_col_o    <= '0;
            dec_corner_o <= 1'b0;
            dec_fixed_o  <= 1'b0;
            dec_uncorr_o <= 1'b0;
        end else begin
            dec_valid_o  <= dec_valid_i;
            dec_fixed_o  <= dec_valid_i & fix_flag;
            dec_uncorr_o <= dec_valid_i & unc_flag;
            if (dec_valid_i) begin
                dec_data_o   <= fix_data;
                dec_row_o    <= fix_row;
                dec_col_o    <= fix_col;
                dec_corner_o <= fix_corner;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o); // R4

    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o); // R4

    AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o); // R4

    AST_CORNER_BOTH_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (enc_corner_o == ^enc_col_o)); // R3

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !dec_fixed_o && !dec_uncorr_o) |->
        (dec_data_o == $past(dec_data_i) && dec_row_o == $past(dec_row_i) &&
         dec_col_o == $past(dec_col_i) && dec_corner_o == $past(dec_corner_i))); // R5

    AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fixed_o |->
        ($countones({dec_data_o ^ $past(dec_data_i), dec_row_o ^ $past(dec_row_i),
                     dec_col_o ^ $past(dec_col_i), dec_corner_o ^ $past(dec_corner_i)}) == 1)); // R6

    AST_UNCORR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr_o |->
        (dec_data_o == $past(dec_data_i) && dec_row_o == $past(dec_row_i) &&
         dec_col_o == $past(dec_col_i) && dec_corner_o == $past(dec_corner_i))); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fixed_o && dec_uncorr_o)); // R10

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> (!dec_fixed_o && !dec_uncorr_o)); // R10
endmodule

// File: tb/rc_parity_codec_tb.sv
module rc_parity_codec_tb;
    localparam int R = 8;
    localparam int C = 8;
    localparam int N = R * C;

    typedef struct packed {
        logic [N-1:0] d;
        logic [R-1:0] rw;
        logic [C-1:0] cl;
        logic         k;
        logic         fx;
        logic         un;
    } dec_exp_t;

    typedef struct packed {
        logic [R-1:0] rw;
        logic [C-1:0] cl;
        logic         k;
    } enc_exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_valid_i = 1'b0;
    logic [N-1:0] enc_data_i = '0;
    logic enc_valid_o;
    logic [R-1:0] enc_row_o;
    logic [C-1:0] enc_col_o;
    logic enc_corner_o;
    logic dec_valid_i = 1'b0;
    logic [N-1:0] dec_data_i = '0;
    logic [R-1:0] dec_row_i = '0;
    logic [C-1:0] dec_col_i = '0;
    logic dec_corner_i = 1'b0;
    logic dec_valid_o;
    logic [N-1:0] dec_data_o;
    logic [R-1:0] dec_row_o;
    logic [C-1:0] dec_col_o;
    logic dec_corner_o, dec_fixed_o, dec_uncorr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dec_exp_t dq[$];
    string    dtag[$];
    enc_exp_t eq[$];
    string    etag[$];

    always #4 clk = ~clk;   // 125 MHz

    rc_parity_codec #(.ROWS(R), .COLS(C)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_row_o(enc_row_o),
        .enc_col_o(enc_col_o), .enc_corner_o(enc_corner_o),
        .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i),
        .dec_row_i(dec_row_i), .dec_col_i(dec_col_i), .dec_corner_i(dec_corner_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_row_o(dec_row_o), .dec_col_o(dec_col_o), .dec_corner_o(dec_corner_o),
        .dec_fixed_o(dec_fixed_o), .dec_uncorr_o(dec_uncorr_o)
    );

    // Reference encoder written from the requirements (R1, R2, R3).
    function automatic enc_exp_t ref_encode(input logic [N-1:0] d);
        enc_exp_t e;
        e.rw = '0;
        e.cl = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                e.rw[r] ^= d[r*C + c];
                e.cl[c] ^= d[r*C + c];
            end
        e.k = 1'b0;
        for (int r = 0; r < R; r++) e.k ^= e.rw[r];
        return e;
    endfunction

    function automatic logic [63:0] mix(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x ^= x << 13;
        x ^= x >> 7;
        x ^= x << 17;
        return x;
    endfunction

    task automatic check(input bit ok, input string what, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", what, act, exp);
        end
    endtask

    // Driver: one encoder request, expected result queued.
    task automatic enc_send(input logic [N-1:0] d, input string tag);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        eq.push_back(ref_encode(d));
        etag.push_back(tag);
    endtask

    // Driver: one decoder request with its expected outcome queued.
    task automatic dec_send(input logic [N-1:0] d, input logic [R-1:0] rw,
                            input logic [C-1:0] cl, input logic k,
                            input dec_exp_t exp, input string tag);
        @(negedge clk);
        dec_valid_i  = 1'b1;
        dec_data_i   = d;
        dec_row_i    = rw;
        dec_col_i    = cl;
        dec_corner_i = k;
        dq.push_back(exp);
        dtag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    function automatic dec_exp_t mk(input logic [N-1:0] d, input enc_exp_t e,
                                    input logic fx, input logic un);
        dec_exp_t x;
        x.d = d; x.rw = e.rw; x.cl = e.cl; x.k = e.k; x.fx = fx; x.un = un;
        return x;
    endfunction

    // Single-error case: corrupt, expect the clean codeword back with fixed set.
    task automatic single(input logic [N-1:0] d, input int kind, input int idx, input string tag);
        enc_exp_t e;
        logic [N-1:0] cd;
        logic [R-1:0] crw;
        logic [C-1:0] ccl;
        logic ck;
        e = ref_encode(d);
        cd = d; crw = e.rw; ccl = e.cl; ck = e.k;
        case (kind)
            0: cd[idx]  = ~cd[idx];
            1: crw[idx] = ~crw[idx];
            2: ccl[idx] = ~ccl[idx];
            default: ck = ~ck;
        endcase
        dec_send(cd, crw, ccl, ck, mk(d, e, 1'b1, 1'b0), tag);
    endtask

    // Double-error case: two flips anywhere in the block (index space:
    // 0..N-1 data, N..N+R-1 rows, N+R..N+R+C-1 columns, N+R+C corner).
    task automatic double_err(input logic [N-1:0] d, input int a, input int b, input string tag);
        enc_exp_t e;
        logic [N+R+C:0] blk;
        dec_exp_t x;
        e = ref_encode(d);
        blk = {e.k, e.cl, e.rw, d};
        blk[a] = ~blk[a];
        blk[b] = ~blk[b];
        x.d = blk[N-1:0]; x.rw = blk[N +: R]; x.cl = blk[N+R +: C]; x.k = blk[N+R+C];
        x.fx = 1'b0; x.un = 1'b1;
        dec_send(x.d, x.rw, x.cl, x.k, x, tag);
    endtask

    // Monitor: encoder results against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && enc_valid_o) begin
            if (eq.size() == 0) begin
                check(1'b0, "R4 unexpected encoder valid", "1", "0");
            end else begin
                enc_exp_t e;
                string t;
                e = eq.pop_front();
                t = etag.pop_front();
                check(enc_row_o == e.rw, {"R1 row checks ", t},
                      $sformatf("%h", enc_row_o), $sformatf("%h", e.rw));
                check(enc_col_o == e.cl, {"R2 column checks ", t},
                      $sformatf("%h", enc_col_o), $sformatf("%h", e.cl));
                check(enc_corner_o == e.k, {"R3 corner ", t},
                      $sformatf("%b", enc_corner_o), $sformatf("%b", e.k));
            end
        end
    end

    // Monitor: decoder results against the scoreboard (flags per R10 too).
    always @(negedge clk) begin
        if (rst_n && dec_valid_o) begin
            if (dq.size() == 0) begin
                check(1'b0, "R4 unexpected decoder valid", "1", "0");
            end else begin
                dec_exp_t x;
                dec_exp_t a;
                string t;
                x = dq.pop_front();
                t = dtag.pop_front();
                a.d = dec_data_o; a.rw = dec_row_o; a.cl = dec_col_o; a.k = dec_corner_o;
                a.fx = dec_fixed_o; a.un = dec_uncorr_o;
                check(a == x, t, $sformatf("%h", a), $sformatf("%h", x));
                check(!(dec_fixed_o && dec_uncorr_o), {"R10 flags exclusive ", t},
                      $sformatf("%b%b", dec_fixed_o, dec_uncorr_o), "not 11");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        logic [N-1:0] p;
        // Reset with input valids high: reset must win (R4).
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b1;
        enc_data_i  = '1;
        dec_data_i  = '1;
        repeat (3) @(negedge clk);
        check(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R4 reset valids",
              $sformatf("%b%b", enc_valid_o, dec_valid_o), "00");
        check(dec_data_o == '0 && enc_row_o == '0 && !dec_fixed_o && !dec_uncorr_o,
              "R4 reset outputs", $sformatf("%h", dec_data_o), "0");
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        rst_n = 1'b1;

        // Encoder patterns (R1, R2, R3).
        enc_send('0, "zero");
        enc_send('1, "ones");
        enc_send({(N/2){2'b10}}, "stripes");
        enc_send(64'h55AA_55AA_55AA_55AA, "checker");
        s = 64'h1234_5678_9ABC_DEF1;
        for (int i = 0; i < 4; i++) begin
            s = mix(s);
            enc_send(s, $sformatf("mix%0d", i));
        end
        idle();
        idle();

        // Clean codewords (R5).
        s = 64'h0F1E_2D3C_4B5A_6978;
        for (int i = 0; i < 4; i++) begin
            enc_exp_t e;
            s = mix(s);
            e = ref_encode(s);
            dec_send(s, e.rw, e.cl, e.k, mk(s, e, 1'b0, 1'b0), $sformatf("R5 clean %0d", i));
        end
        begin
            enc_exp_t e;
            e = ref_encode('1);
            dec_send('1, e.rw, e.cl, e.k, mk('1, e, 1'b0, 1'b0), "R5 clean ones");
        end

        // Every single data bit (R6).
        p = mix(64'hDEAD_BEEF_0BAD_F00D);
        for (int i = 0; i < N; i++) single(p, 0, i, $sformatf("R6 data bit %0d", i));
        // Every row check and column check (R7).
        for (int i = 0; i < R; i++) single(p, 1, i, $sformatf("R7 row check %0d", i));
        for (int i = 0; i < C; i++) single(p, 2, i, $sformatf("R7 column check %0d", i));
        // Corner (R8).
        single(p, 3, 0, "R8 corner");
        single('0, 3, 0, "R8 corner on zero block");
        idle();

        // Idle gap: no valid, no flags (R4, R10).
        idle();
        check(dec_valid_o == 1'b0 && !dec_fixed_o && !dec_uncorr_o, "R10 flags idle",
              $sformatf("%b%b%b", dec_valid_o, dec_fixed_o, dec_uncorr_o), "000");

        // Double errors (R9).
        double_err(p, 0, 1, "R9 two bits same row");
        double_err(p, 3, 3 + 2*C, "R9 two bits same column");
        double_err(p, 9, 54, "R9 two bits unrelated");
        double_err(p, 2*C + 5, N + 2, "R9 data plus its row check");
        double_err(p, 2*C + 5, N + R + 5, "R9 data plus its column check");
        double_err(p, N + 1, N + R + 6, "R9 row check plus column check");
        double_err(p, N + 4, N + R + C, "R9 row check plus corner");
        double_err(p, N + 1, N + 6, "R9 two row checks");
        double_err('0, 0, N - 1, "R9 opposite corners of zero block");
        idle();

        while (dq.size() != 0 || eq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule